// File: doc/BRIEF.md
# Partial-Sum Accumulate Write Controller

This block sits between a matrix-multiply array and its partial-sum buffer. Each cycle it may accept one fp32 result word, together with two command flags, an optional per-function override, a log2 bank-clear count and a destination. From these it decides one of three behaviours. A group head clears whole banks and then stores the word. A group body adds the word into what is already stored, using fp32 arithmetic. An idle write overwrites the word and clears nothing.

The buffer has `NUM_BANKS` banks. Each bank holds `PARTS` partitions of `PART_DEPTH` words. A flat word address maps to bank = addr / (PARTS*PART_DEPTH). A clear resets every partition of each affected bank, and clearing is done by dropping per-word valid bits, so a cleared word reads as 0.0. The read-add-write path has two stages and forwards data between commands that follow each other closely, so no update is lost. A separate drain port reads the buffer back. Commands that are illegal raise a one-cycle error with a code and change nothing.

Top module: `psum_accum_ctrl`

## Requirements
- R1: With no override and `cmd_start`=1, the command is a group head. It clears the destination bank range and then stores `res_data` at `dst_addr`, so every other word in the cleared banks reads 0.
- R2: With no override, `cmd_start`=0 and `cmd_accum`=1, the command is a group body. The stored word becomes old + `res_data` in fp32, and nothing is cleared.
- R3: With no override, `cmd_start`=0 and `cmd_accum`=0, the command is idle. It overwrites the word and clears nothing.
- R4: When `ovr_present`=1, the flags are ignored. `ovr_accum`=1 selects a group body (add, no clear) and `ovr_accum`=0 selects a group head (clear, then store).
- R5: A head clears 2^`clr_log2` consecutive banks, starting at the bank that holds `dst_addr`.
- R6: When `MULTIBANK_EN`=0, a head with `clr_log2`≠0 raises error code 3. Nothing is cleared or written.
- R7: A head whose bank range extends past the last bank raises error code 4. Nothing is cleared or written.
- R8: A command with `cmd_start`=1 and `dst_kind`≠0 (0 means partial-sum buffer, 1 SBUF, 2 DRAM) raises error code 2 and changes nothing. A non-start command to a non-buffer destination is dropped without an error.
- R9: A `dst_addr` ≥ NUM_BANKS*PARTS*PART_DEPTH raises error code 1 and writes nothing. Error priority is: code 1, then 2, then 3, then 4.
- R10: Accumulates issued back to back, or two cycles apart, to the same word all take effect.
- R11: `rd_valid` and `rd_data` follow `rd_en` by one cycle. After reset every word reads 0 and `err_valid`=0. `err_valid` is a one-cycle pulse that follows the erroneous command by one cycle.
- R12: The add is IEEE-754 binary32 with round-to-nearest-even. Exact cancellation gives +0, and subnormal results are flushed to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_start | input | 1 | Group-head flag |
| cmd_accum | input | 1 | Accumulate flag |
| ovr_present | input | 1 | Per-function override is present |
| ovr_accum | input | 1 | Override value: 1 = accumulate, 0 = head |
| clr_log2 | input | CLR_W | log2 of the number of banks to clear on a head |
| dst_kind | input | 2 | Destination memory: 0 buffer, 1 SBUF, 2 DRAM |
| dst_addr | input | ADDR_W | Flat word address |
| res_data | input | 32 | fp32 result word |
| err_valid | output | 1 | Error pulse |
| err_code | output | 3 | 1 address, 2 destination, 3 multibank, 4 clear range |
| rd_en | input | 1 | Drain read request |
| rd_addr | input | AW | Drain read address |
| rd_valid | output | 1 | Drain data valid |
| rd_data | output | 32 | Drain read data |

## Verification
The assertions rely on a few assumptions about the inputs. Command fields are taken to be meaningful only while `cmd_valid` is high, and `rd_en` is taken to be low while reset is asserted. A drain read is assumed never to hit a word in the same cycle that word is written, because the read is read-first and would return the older value. The stimulus meets these assumptions: it drives inputs on the falling edge, holds `rd_en` low during reset, and leaves one idle cycle after each command before reading back. Bursts that exercise forwarding do not read back until the pipeline has drained.

// File: rtl/psum_ctrl_pkg.sv
package psum_ctrl_pkg;
  typedef enum logic [1:0] {
    DST_PSUM  = 2'd0,
    DST_SBUF  = 2'd1,
    DST_DRAM  = 2'd2,
    DST_OTHER = 2'd3
  } dst_kind_e;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_ADDR  = 3'd1,
    ERR_DEST  = 3'd2,
    ERR_MBANK = 3'd3,
    ERR_CLR   = 3'd4
  } err_e;
endpackage

// File: rtl/psum_cmd_decode.sv
module psum_cmd_decode
  import psum_ctrl_pkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int BANK_WORDS   = 16,
  parameter int ADDR_W       = 7,
  parameter int CLR_W        = 3,
  parameter bit MULTIBANK_EN = 1'b1
) (
  input  logic                 cmd_start,
  input  logic                 cmd_accum,
  input  logic                 ovr_present,
  input  logic                 ovr_accum,
  input  logic [CLR_W-1:0]     clr_log2,
  input  logic [1:0]           dst_kind,
  input  logic [ADDR_W-1:0]    dst_addr,
  output logic                 do_write,
  output logic                 do_acc,
  output logic [NUM_BANKS-1:0] clr_mask,
  output logic [2:0]           err_code
);
  localparam int WORDS   = NUM_BANKS * BANK_WORDS;
  localparam int BANK_SH = $clog2(BANK_WORDS);
  localparam int BANK_W  = $clog2(NUM_BANKS);
  localparam int SPAN_W  = (1 << CLR_W) + BANK_W + 1;

  logic              addr_oob, is_psum, head, acc;
  logic [BANK_W-1:0] bank;
  logic [SPAN_W-1:0] first, cnt, last;
  err_e              err;

  assign addr_oob = dst_addr >= ADDR_W'(WORDS);
  assign is_psum  = dst_kind == DST_PSUM;
  assign bank     = dst_addr[BANK_SH +: BANK_W];
  assign head     = ovr_present ? ~ovr_accum : cmd_start;
  assign acc      = ovr_present ? ovr_accum : (~cmd_start & cmd_accum);
  assign first    = SPAN_W'(bank);
  assign cnt      = SPAN_W'(1) << clr_log2;
  assign last     = first + cnt;

  always_comb begin
    err = ERR_NONE;
    if (addr_oob)
      err = ERR_ADDR;
    else if (cmd_start && !is_psum)
      err = ERR_DEST;
    else if (head && is_psum && (clr_log2 != '0) && !MULTIBANK_EN)
      err = ERR_MBANK;
    else if (head && is_psum && (last > SPAN_W'(NUM_BANKS)))
      err = ERR_CLR;
  end

  assign err_code = err;
  assign do_write = (err == ERR_NONE) && is_psum;
  assign do_acc   = acc;

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_mask
    assign clr_mask[k] = do_write && head &&
                         (SPAN_W'(k) >= first) && (SPAN_W'(k) < last);
  end
endmodule

// File: rtl/psum_fp32_add.sv
module psum_fp32_add (
  input  logic [31:0] a,
  input  logic [31:0] b,
  output logic [31:0] sum
);
  logic        sa, sb, sl, ss;
  logic [7:0]  ea, eb, el, es, d;
  logic [23:0] ma, mb, ml, ms, mant;
  logic [26:0] xl, xs0, xs, nrm;
  logic [27:0] s28;
  logic [24:0] m25;
  logic [9:0]  e;
  logic [4:0]  sh, pos;
  logic        stk, g, rs, up;

  always_comb begin
    sa = a[31]; ea = a[30:23]; ma = (ea == 8'd0) ? 24'd0 : {1'b1, a[22:0]};
    sb = b[31]; eb = b[30:23]; mb = (eb == 8'd0) ? 24'd0 : {1'b1, b[22:0]};
    if ({ea, ma} < {eb, mb}) begin
      sl = sb; el = eb; ml = mb; ss = sa; es = ea; ms = ma;
    end else begin
      sl = sa; el = ea; ml = ma; ss = sb; es = eb; ms = mb;
    end
    d   = el - es;
    xl  = {ml, 3'b000};
    xs0 = {ms, 3'b000};
    if (d >= 8'd27) begin
      xs  = '0;
      stk = |xs0;
    end else begin
      xs  = xs0 >> d;
      stk = |(xs0 & ((27'd1 << d) - 27'd1));
    end
    xs[0] = xs[0] | stk;
    if (sl == ss) s28 = {1'b0, xl} + {1'b0, xs};
    else          s28 = {1'b0, xl} - {1'b0, xs};
    e   = {2'b00, el};
    pos = 5'd0;
    for (int i = 0; i < 27; i++) if (s28[i]) pos = 5'(i);
    sh  = 5'd26 - pos;
    if (s28[27]) begin
      nrm = s28[27:1] | {26'd0, s28[0]};
      e   = e + 10'd1;
    end else begin
      nrm = s28[26:0] << sh;
      e   = e - {5'd0, sh};
    end
    mant = nrm[26:3];
    g    = nrm[2];
    rs   = nrm[1] | nrm[0];
    up   = g & (rs | mant[0]);
    m25  = {1'b0, mant} + {24'd0, up};
    if (m25[24]) begin
      mant = m25[24:1];
      e    = e + 10'd1;
    end else begin
      mant = m25[23:0];
    end
    if (s28 == 28'd0)
      sum = 32'd0;
    else if (e[9] || e == 10'd0)
      sum = {sl, 31'd0};
    else if (e >= 10'd255)
      sum = {sl, 8'hFF, 23'd0};
    else
      sum = {sl, e[7:0], mant[22:0]};
  end
endmodule

// File: rtl/psum_bank_store.sv
module psum_bank_store #(
  parameter int WORDS     = 64,
  parameter int NUM_BANKS = 4,
  parameter int BANK_SH   = 4,
  parameter int DATA_W    = 32,
  localparam int AW       = $clog2(WORDS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_BANKS-1:0] clr_mask,
  input  logic [AW-1:0]        ra_addr,
  output logic [DATA_W-1:0]    ra_data,
  output logic                 ra_hit,
  input  logic [AW-1:0]        rb_addr,
  output logic [DATA_W-1:0]    rb_data,
  output logic                 rb_hit
);
  logic [DATA_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  vld, set_w, clr_w;

  for (genvar w = 0; w < WORDS; w++) begin : g_clr
    assign clr_w[w] = clr_mask[w >> BANK_SH];
  end

  assign set_w = we ? (WORDS'(1) << waddr) : '0;

  // a clear issued in the same cycle is younger than the pending write
  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= '0;
      ra_hit <= 1'b0;
      rb_hit <= 1'b0;
    end else begin
      vld    <= (vld | set_w) & ~clr_w;
      ra_hit <= vld[ra_addr];
      rb_hit <= vld[rb_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end
endmodule

// File: rtl/psum_accum_ctrl.sv
module psum_accum_ctrl
  import psum_ctrl_pkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int PARTS        = 2,
  parameter int PART_DEPTH   = 8,
  parameter int CLR_W        = 3,
  parameter bit MULTIBANK_EN = 1'b1,
  localparam int BANK_WORDS  = PARTS * PART_DEPTH,
  localparam int WORDS       = NUM_BANKS * BANK_WORDS,
  localparam int AW          = $clog2(WORDS),
  localparam int ADDR_W      = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_start,
  input  logic              cmd_accum,
  input  logic              ovr_present,
  input  logic              ovr_accum,
  input  logic [CLR_W-1:0]  clr_log2,
  input  logic [1:0]        dst_kind,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [31:0]       res_data,
  output logic              err_valid,
  output logic [2:0]        err_code,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic              rd_valid,
  output logic [31:0]       rd_data
);
  localparam int BANK_SH = $clog2(BANK_WORDS);

  logic                 dec_write, dec_acc;
  logic [NUM_BANKS-1:0] dec_mask, clr_now;
  logic [2:0]           dec_code;
  logic                 s0_go;

  logic                 s1_we, s1_acc, fwd_hit;
  logic [AW-1:0]        s1_addr;
  logic [31:0]          s1_prod, fwd_data, s1_old, s1_sum, s1_wdata;
  logic [31:0]          ra_data, rb_data;
  logic                 ra_hit, rb_hit;

  psum_cmd_decode #(
    .NUM_BANKS(NUM_BANKS), .BANK_WORDS(BANK_WORDS), .ADDR_W(ADDR_W),
    .CLR_W(CLR_W), .MULTIBANK_EN(MULTIBANK_EN)
  ) u_dec (
    .cmd_start(cmd_start), .cmd_accum(cmd_accum),
    .ovr_present(ovr_present), .ovr_accum(ovr_accum),
    .clr_log2(clr_log2), .dst_kind(dst_kind), .dst_addr(dst_addr),
    .do_write(dec_write), .do_acc(dec_acc), .clr_mask(dec_mask),
    .err_code(dec_code)
  );

  assign s0_go   = cmd_valid & dec_write;
  assign clr_now = cmd_valid ? dec_mask : '0;

  psum_bank_store #(
    .WORDS(WORDS), .NUM_BANKS(NUM_BANKS), .BANK_SH(BANK_SH), .DATA_W(32)
  ) u_store (
    .clk(clk), .rst(rst),
    .we(s1_we), .waddr(s1_addr), .wdata(s1_wdata), .clr_mask(clr_now),
    .ra_addr(dst_addr[AW-1:0]), .ra_data(ra_data), .ra_hit(ra_hit),
    .rb_addr(rd_addr), .rb_data(rb_data), .rb_hit(rb_hit)
  );

  // old value: freshest of forwarded write, stored word, or cleared zero
  assign s1_old   = fwd_hit ? fwd_data : (ra_hit ? ra_data : 32'd0);

  psum_fp32_add u_add (.a(s1_old), .b(s1_prod), .sum(s1_sum));

  assign s1_wdata = s1_acc ? s1_sum : s1_prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_we     <= 1'b0;
      s1_acc    <= 1'b0;
      s1_addr   <= '0;
      s1_prod   <= '0;
      fwd_hit   <= 1'b0;
      fwd_data  <= '0;
      err_valid <= 1'b0;
      err_code  <= ERR_NONE;
      rd_valid  <= 1'b0;
    end else begin
      s1_we     <= s0_go;
      s1_acc    <= dec_acc;
      s1_addr   <= dst_addr[AW-1:0];
      s1_prod   <= res_data;
      fwd_hit   <= s0_go && s1_we && (s1_addr == dst_addr[AW-1:0]);
      fwd_data  <= s1_wdata;
      err_valid <= cmd_valid && (dec_code != ERR_NONE);
      err_code  <= cmd_valid ? dec_code : ERR_NONE;
      rd_valid  <= rd_en;
    end
  end

  assign rd_data = rb_hit ? rb_data : 32'd0;
endmodule

// File: rtl/psum_accum_ctrl_chk.sv
module psum_accum_ctrl_chk #(
  parameter int ADDR_W       = 7,
  parameter int WORDS        = 64,
  parameter int CLR_W        = 3,
  parameter bit MULTIBANK_EN = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_start,
  input logic              ovr_present,
  input logic [CLR_W-1:0]  clr_log2,
  input logic [1:0]        dst_kind,
  input logic [ADDR_W-1:0] dst_addr,
  input logic              err_valid,
  input logic [2:0]        err_code,
  input logic              rd_en,
  input logic              rd_valid,
  input logic              s1_we
);
  // R9
  addr_oob_err_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && (dst_addr >= ADDR_W'(WORDS)) |=> err_valid && err_code == 3'd1);

  // R8
  dest_start_err_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && (dst_addr < ADDR_W'(WORDS)) && cmd_start && dst_kind != 2'd0
    |=> err_valid && err_code == 3'd2);

  // R6
  multibank_err_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !MULTIBANK_EN && (dst_addr < ADDR_W'(WORDS)) && dst_kind == 2'd0 &&
    !ovr_present && cmd_start && clr_log2 != '0 |=> err_valid && err_code == 3'd3);

  // R9
  err_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> !s1_we);

  // R11
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
endmodule

bind psum_accum_ctrl psum_accum_ctrl_chk #(
  .ADDR_W(ADDR_W), .WORDS(WORDS), .CLR_W(CLR_W), .MULTIBANK_EN(MULTIBANK_EN)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_start(cmd_start),
  .ovr_present(ovr_present), .clr_log2(clr_log2), .dst_kind(dst_kind),
  .dst_addr(dst_addr), .err_valid(err_valid), .err_code(err_code),
  .rd_en(rd_en), .rd_valid(rd_valid), .s1_we(s1_we)
);

// File: tb/psum_accum_ctrl_tb.sv
`timescale 1ns/1ps
module psum_accum_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 0, cmd_start = 0, cmd_accum = 0, ovr_present = 0, ovr_accum = 0;
  logic [2:0]  clr_log2 = 0;
  logic [1:0]  dst_kind = 0;
  logic [6:0]  dst_addr = 0;
  logic [31:0] res_data = 0;
  logic        rd_en = 0;
  logic [5:0]  rd_addr = 0;
  logic        err_valid, err_valid1, rd_valid, rd_valid1;
  logic [2:0]  err_code, err_code1;
  logic [31:0] rd_data, rd_data1;

  int n_tests = 0;
  int n_fail  = 0;
  logic        got_err, got_err1;
  logic [2:0]  got_code, got_code1;
  logic [31:0] val, val1;

  always #2.5 clk = ~clk;

  psum_accum_ctrl u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_start(cmd_start),
    .cmd_accum(cmd_accum), .ovr_present(ovr_present), .ovr_accum(ovr_accum),
    .clr_log2(clr_log2), .dst_kind(dst_kind), .dst_addr(dst_addr),
    .res_data(res_data), .err_valid(err_valid), .err_code(err_code),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  psum_accum_ctrl #(.MULTIBANK_EN(1'b0)) u_dut1 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_start(cmd_start),
    .cmd_accum(cmd_accum), .ovr_present(ovr_present), .ovr_accum(ovr_accum),
    .clr_log2(clr_log2), .dst_kind(dst_kind), .dst_addr(dst_addr),
    .res_data(res_data), .err_valid(err_valid1), .err_code(err_code1),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid1), .rd_data(rd_data1)
  );

  function automatic logic [31:0] fp(input int v);
    logic [31:0] r, m;
    int p;
    if (v == 0) return 32'd0;
    m = (v < 0) ? 32'(-v) : 32'(v);
    p = 0;
    for (int i = 0; i < 31; i++) if (m[i]) p = i;
    r[31]    = v < 0;
    r[30:23] = 8'(127 + p);
    if (p <= 23) r[22:0] = 23'(m << (23 - p));
    else         r[22:0] = 23'(m >> (p - 23));
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input bit st, input bit ac, input bit op, input bit ov,
                       input int lg, input int kind, input int addr, input logic [31:0] d);
    cmd_valid = 1; cmd_start = st; cmd_accum = ac; ovr_present = op; ovr_accum = ov;
    clr_log2 = 3'(lg); dst_kind = 2'(kind); dst_addr = 7'(addr); res_data = d;
  endtask

  task automatic send(input bit st, input bit ac, input bit op, input bit ov,
                      input int lg, input int kind, input int addr, input logic [31:0] d);
    @(negedge clk);
    drive(st, ac, op, ov, lg, kind, addr, d);
    @(negedge clk);
    cmd_valid = 0;
    got_err = err_valid; got_code = err_code;
    got_err1 = err_valid1; got_code1 = err_code1;
    @(negedge clk);
  endtask

  task automatic rd(input int addr);
    rd_en = 1; rd_addr = 6'(addr);
    @(negedge clk);
    rd_en = 0;
    val = rd_data; val1 = rd_data1;
    chk("R11 rd_valid", {31'd0, rd_valid}, 32'd1);
  endtask

  task automatic t_reset;
    rd(0);
    chk("R11 reset word", val, 32'd0);
    chk("R11 reset err", {31'd0, err_valid}, 32'd0);
  endtask

  task automatic t_multibank;
    send(0, 0, 0, 0, 0, 0, 16, fp(6));
    send(1, 0, 0, 0, 1, 0, 0, fp(1));
    chk("R6 err code", {29'd0, got_code1}, 32'd3);
    chk("R5 no err", {31'd0, got_err}, 32'd0);
    rd(16);
    chk("R6 unchanged", val1, fp(6));
    chk("R5 bank1 cleared", val, 32'd0);
    rd(0);
    chk("R6 no write", val1, 32'd0);
    chk("R1 head stored", val, fp(1));
  endtask

  task automatic t_idle;
    send(0, 0, 0, 0, 0, 0, 2, fp(5));
    rd(2); chk("R3 idle write", val, fp(5));
    send(0, 0, 0, 0, 0, 0, 2, fp(8));
    rd(2); chk("R3 overwrite", val, fp(8));
    rd(0); chk("R3 no clear", val, fp(1));
  endtask

  task automatic t_body;
    send(0, 1, 0, 0, 0, 0, 2, fp(3));
    rd(2); chk("R2 add", val, fp(11));
    send(0, 1, 0, 0, 0, 0, 2, fp(-4));
    rd(2); chk("R2 add negative", val, fp(7));
  endtask

  task automatic t_head;
    send(0, 0, 0, 0, 0, 0, 17, fp(9));
    send(1, 1, 0, 0, 0, 0, 3, fp(2));
    rd(3);  chk("R1 head word", val, fp(2));
    rd(2);  chk("R1 bank cleared", val, 32'd0);
    rd(17); chk("R5 other bank kept", val, fp(9));
  endtask

  task automatic t_clr_oob;
    send(0, 0, 0, 0, 0, 0, 48, fp(4));
    send(1, 0, 0, 0, 1, 0, 48, fp(1));
    chk("R7 err code", {29'd0, got_code}, 32'd4);
    rd(48); chk("R7 unchanged", val, fp(4));
  endtask

  task automatic t_dest;
    send(1, 0, 0, 0, 0, 1, 17, fp(1));
    chk("R8 err code", {29'd0, got_code}, 32'd2);
    rd(17); chk("R8 unchanged", val, fp(9));
    send(0, 0, 0, 0, 0, 2, 17, fp(1));
    chk("R8 silent drop", {31'd0, got_err}, 32'd0);
    rd(17); chk("R8 dropped", val, fp(9));
  endtask

  task automatic t_oob;
    send(0, 0, 0, 0, 0, 0, 64, fp(12));
    chk("R9 err code", {29'd0, got_code}, 32'd1);
    rd(0); chk("R9 no alias write", val, 32'd0);
  endtask

  task automatic t_override;
    send(0, 0, 0, 0, 0, 0, 33, fp(5));
    send(1, 0, 1, 1, 0, 0, 32, fp(2));
    rd(32); chk("R4 forced accumulate", val, fp(2));
    rd(33); chk("R4 no clear", val, fp(5));
    send(0, 1, 1, 0, 0, 0, 32, fp(7));
    rd(32); chk("R4 forced head", val, fp(7));
    rd(33); chk("R4 forced clear", val, 32'd0);
  endtask

  task automatic t_b2b;
    @(negedge clk); drive(1, 0, 0, 0, 0, 0, 40, fp(1));
    @(negedge clk); drive(0, 1, 0, 0, 0, 0, 40, fp(1));
    @(negedge clk); drive(0, 1, 0, 0, 0, 0, 40, fp(1));
    @(negedge clk); drive(0, 1, 0, 0, 0, 0, 40, fp(1));
    @(negedge clk); drive(0, 1, 0, 0, 0, 0, 41, fp(1));
    @(negedge clk); drive(0, 1, 0, 0, 0, 0, 40, fp(10));
    @(negedge clk); drive(0, 1, 0, 0, 0, 0, 41, fp(2));
    @(negedge clk); cmd_valid = 0;
    repeat (2) @(negedge clk);
    rd(40); chk("R10 chain", val, fp(14));
    rd(41); chk("R10 gap of two", val, fp(3));
  endtask

  task automatic t_fp;
    send(0, 0, 0, 0, 0, 0, 8, fp(16777216));
    send(0, 1, 0, 0, 0, 0, 8, fp(1));
    rd(8); chk("R12 tie to even down", val, fp(16777216));
    send(0, 1, 0, 0, 0, 0, 8, fp(3));
    rd(8); chk("R12 tie to even up", val, fp(16777220));
    send(0, 0, 0, 0, 0, 0, 9, fp(3));
    send(0, 1, 0, 0, 0, 0, 9, fp(-3));
    rd(9); chk("R12 cancel", val, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_multibank();
    t_idle();
    t_body();
    t_head();
    t_clr_oob();
    t_dest();
    t_oob();
    t_override();
    t_b2b();
    t_fp();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual running expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule